// File: doc/BRIEF.md
# Two-Tier Round-Robin Bus Arbiter with Grant Parking

This block decides which agent owns a shared secondary PCI-style bus. There are up to eight external masters, each with an active-low request and grant pair, and one internal bridge agent with an active-high request and grant. A 32-bit configuration word puts each agent in either a high tier or a low tier. Agents in the same tier take turns in round-robin order. The low tier as a whole holds one position in the high tier's rotation, so a low-tier master is served after each full pass of the high tier and is never starved.

The grant moves only in a bus-idle cycle, and only when nobody is granted or the current owner has dropped its request. When the grant moves from one agent to another, one cycle with no grant is placed between them. If no agent is requesting, the grant is parked. A configuration bit selects where it parks: it stays on the last owner, or it goes to the bridge. Configuration writes are stored at once but only act at arbitration decisions, so they never take away a grant that is in use.

Top module: `dual_tier_arbiter`

## Requirements
- R1: While reset is asserted no grant is driven (`gnt_n` all ones, `brg_gnt` low), and the configuration reads 0x0200_0000: every external agent is in the low tier, the bridge is in the high tier, and parking is on the last owner.
- R2: In the configuration word, bit 16+i holds the tier of external agent i (0 low, 1 high), bit 25 holds the bridge's tier, and bit 26 holds the parking choice (0 last owner, 1 bridge). Bit 24 and bits 31:27 read as 0 and ignore writes. With 7 external agents, bit 23 also reads as 0. A write appears on `cfg_rdata` one cycle later.
- R3: At most one grant is asserted at any time, counting the bridge grant.
- R4: When the grant moves from one agent to a different agent, at least one cycle with no grant lies between the two grants.
- R5: The grant never changes in a cycle where `bus_idle` is low.
- R6: Within a tier, requesters are served round-robin by agent index (external 0 to N-1, then the bridge as index N), starting after the last agent served from that tier.
- R7: A high-tier requester is served ahead of low-tier requesters. After each full pass over the high-tier requesters, exactly one low-tier requester is served.
- R8: With parking on the last owner, the grant stays on that owner while no agent requests. Coming out of reset, the bridge counts as the last owner.
- R9: With parking on the bridge, the grant moves to the bridge whenever no agent requests.
- R10: While the owner keeps its request asserted, neither other requests nor configuration writes move the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_n | input | NUM_EXT | Active-low requests of the external masters |
| brg_req | input | 1 | Active-high request of the internal bridge agent |
| bus_idle | input | 1 | High when the bus has no transaction in progress |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| gnt_n | output | NUM_EXT | Active-low grants to the external masters |
| brg_gnt | output | 1 | Active-high grant to the bridge agent |

## Verification
The hardest case to reach from the ports is the low tier's single slot in the high rotation. To see it, high-tier masters must come back with a new request between their own grants, so that a second high pass exists for the low slot to fall between. The bench models each master as an agent that drops its request as soon as it sees its grant, then raises it again a cycle later while it still has transactions left. This produces a high, high, low, high, high, low sequence with pointers that carry over from earlier scenarios. A separate held-request master, with the bus marked busy, shows that the grant stays put through tier changes and competing requests.

// File: rtl/dta_pkg.sv
package dta_pkg;

  // Field positions in the configuration word; software depends on them.
  localparam int CFG_GRP_LSB  = 16;
  localparam int CFG_BRG_BIT  = 25;
  localparam int CFG_PARK_BIT = 26;

  // Grant state: nothing granted yet, turnaround gap, grant held.
  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_GAP  = 2'd1,
    ST_HOLD = 2'd2
  } gstate_e;

  // Writable bits of the configuration word for a given agent count.
  function automatic logic [31:0] cfg_wmask(int n_ext);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < n_ext; i++) m[CFG_GRP_LSB + i] = 1'b1;
    m[CFG_BRG_BIT]  = 1'b1;
    m[CFG_PARK_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/dta_cfg_reg.sv
module dta_cfg_reg
  import dta_pkg::*;
#(
  parameter int NUM_EXT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [31:0]        wdata,
  output logic [NUM_EXT-1:0] grp_ext,
  output logic               brg_grp,
  output logic               park_brg,
  output logic [31:0]        rdata
);

  localparam logic [31:0] WMASK = cfg_wmask(NUM_EXT);

  logic [NUM_EXT-1:0] grp_q, grp_d;
  logic               brg_q, brg_d;
  logic               park_q, park_d;

  always_comb begin
    grp_d  = wdata[CFG_GRP_LSB +: NUM_EXT];
    brg_d  = wdata[CFG_BRG_BIT];
    park_d = wdata[CFG_PARK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      brg_q  <= 1'b1;
      park_q <= 1'b0;
    end else if (wr) begin
      grp_q  <= grp_d;
      brg_q  <= brg_d;
      park_q <= park_d;
    end
  end

  always_comb begin
    rdata                          = '0;
    rdata[CFG_GRP_LSB +: NUM_EXT]  = grp_q;
    rdata[CFG_BRG_BIT]             = brg_q;
    rdata[CFG_PARK_BIT]            = park_q;
  end

  assign grp_ext  = grp_q;
  assign brg_grp  = brg_q;
  assign park_brg = park_q;

  // Reserved write bits are dropped on purpose.
  logic unused_wbits;
  assign unused_wbits = ^(wdata & ~WMASK);

endmodule

// File: rtl/dta_rr_pick.sv
module dta_rr_pick #(
  parameter int N  = 9,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [IW-1:0] idx
);

  function automatic logic [IW-1:0] slot_at(logic [IW-1:0] p, int k);
    return IW'((int'(p) + k) % N);
  endfunction

  // Search starts one past the pointer; the smallest distance wins.
  always_comb begin
    idx = ptr;
    for (int k = N; k >= 1; k--) begin
      if (req[slot_at(ptr, k)]) idx = slot_at(ptr, k);
    end
  end

endmodule

// File: rtl/dual_tier_arbiter.sv
module dual_tier_arbiter
  import dta_pkg::*;
#(
  parameter int NUM_EXT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] req_n,
  input  logic               brg_req,
  input  logic               bus_idle,
  input  logic               cfg_wr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic [NUM_EXT-1:0] gnt_n,
  output logic               brg_gnt
);

  localparam int NAG   = NUM_EXT + 1;        // agents incl. bridge
  localparam int NSLOT = NAG + 1;            // high ring incl. low-tier slot
  localparam int AW    = $clog2(NSLOT);
  localparam logic [AW-1:0] BRG_ID     = AW'(NUM_EXT);
  localparam logic [AW-1:0] LOW_SLOT   = AW'(NAG);
  localparam logic [AW-1:0] LO_PTR_RST = AW'(NAG - 1);

  if (NUM_EXT != 7 && NUM_EXT != 8) begin : g_bad_cfg
    $error("dual_tier_arbiter: NUM_EXT must be 7 or 8");
  end

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // Configuration
  logic [NUM_EXT-1:0] grp_ext;
  logic               brg_grp, park_brg;

  dta_cfg_reg #(.NUM_EXT(NUM_EXT)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr       (cfg_wr),
    .wdata    (cfg_wdata),
    .grp_ext  (grp_ext),
    .brg_grp  (brg_grp),
    .park_brg (park_brg),
    .rdata    (cfg_rdata)
  );

  // Request vectors per tier
  logic [NAG-1:0]   req_v, grp_v, hi_req, lo_req;
  logic [NSLOT-1:0] hi_ring;
  logic             any_req;

  always_comb begin
    req_v   = {brg_req, ~req_n};
    grp_v   = {brg_grp, grp_ext};
    hi_req  = req_v & grp_v;
    lo_req  = req_v & ~grp_v;
    hi_ring = {|lo_req, hi_req};
    any_req = |req_v;
  end

  logic [AW-1:0] hptr_q, hptr_d, lptr_q, lptr_d;
  logic [AW-1:0] hi_idx, lo_idx;

  dta_rr_pick #(.N(NSLOT), .IW(AW)) hi_pick_i (
    .req (hi_ring),
    .ptr (hptr_q),
    .idx (hi_idx)
  );

  dta_rr_pick #(.N(NAG), .IW(AW)) lo_pick_i (
    .req (lo_req),
    .ptr (lptr_q),
    .idx (lo_idx)
  );

  // Grant control
  gstate_e       st_q, st_d;
  logic [AW-1:0] own_q, own_d;
  logic [AW-1:0] winner, target;
  logic          owner_req, decide, hptr_en, lptr_en;

  always_comb begin
    winner    = (hi_idx == LOW_SLOT) ? lo_idx : hi_idx;
    target    = any_req ? winner : (park_brg ? BRG_ID : own_q);
    owner_req = req_v[own_q];
    decide    = bus_idle && (st_q == ST_NONE || (st_q == ST_HOLD && !owner_req));
    hptr_en   = decide && any_req;
    lptr_en   = hptr_en && (hi_idx == LOW_SLOT);
    hptr_d    = hi_idx;
    lptr_d    = lo_idx;

    st_d  = st_q;
    own_d = own_q;
    case (st_q)
      ST_GAP: st_d = ST_HOLD;
      ST_NONE: begin
        if (decide) begin
          own_d = target;
          st_d  = ST_HOLD;
        end
      end
      default: begin
        if (decide && target != own_q) begin
          own_d = target;
          st_d  = ST_GAP;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q  <= ST_NONE;
      own_q <= BRG_ID;
    end else begin
      st_q  <= st_d;
      own_q <= own_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  hptr_q <= LOW_SLOT;
    else if (hptr_en) hptr_q <= hptr_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  lptr_q <= LO_PTR_RST;
    else if (lptr_en) lptr_q <= lptr_d;
  end

  // Grant decode from the owner index
  logic [NAG-1:0] gnt_v;
  always_comb begin
    for (int i = 0; i < NAG; i++) begin
      gnt_v[i] = (st_q == ST_HOLD) && (own_q == AW'(i));
    end
  end

  assign gnt_n   = ~gnt_v[NUM_EXT-1:0];
  assign brg_gnt = gnt_v[NUM_EXT];

endmodule

// File: rtl/dta_chk.sv
module dta_chk
  import dta_pkg::*;
#(
  parameter int NUM_EXT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EXT-1:0] req_n,
  input logic               brg_req,
  input logic               bus_idle,
  input logic               cfg_wr,
  input logic [31:0]        cfg_wdata,
  input logic [31:0]        cfg_rdata,
  input logic [NUM_EXT-1:0] gnt_n,
  input logic               brg_gnt
);

  localparam logic [31:0] WMASK = cfg_wmask(NUM_EXT);

  logic [NUM_EXT:0] gv, rv;
  logic             gany;
  assign gv   = {brg_gnt, ~gnt_n};
  assign rv   = {brg_req, ~req_n};
  assign gany = |gv;

  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gv));

  // R4
  turnaround_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gany |=> (!(|gv) || $stable(gv)));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gany && !bus_idle) |=> $stable(gv));

  // R10
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gany && (|(gv & rv))) |=> $stable(gv));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~WMASK) == 32'h0);

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_rdata == ($past(cfg_wdata) & WMASK)));

endmodule

bind dual_tier_arbiter dta_chk #(.NUM_EXT(NUM_EXT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_n     (req_n),
  .brg_req   (brg_req),
  .bus_idle  (bus_idle),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .gnt_n     (gnt_n),
  .brg_gnt   (brg_gnt)
);

// File: tb/dual_tier_arbiter_tb_top.sv
module dual_tier_arbiter_tb_top;

  localparam int NUM_EXT = 8;
  localparam int NAG     = NUM_EXT + 1;
  localparam int BRG     = NUM_EXT;

  logic               clk;
  logic               rst_n;
  logic [NUM_EXT-1:0] req_n;
  logic               brg_req;
  logic               bus_idle;
  logic               cfg_wr;
  logic [31:0]        cfg_wdata;
  logic [31:0]        cfg_rdata;
  logic [NUM_EXT-1:0] gnt_n;
  logic               brg_gnt;

  dual_tier_arbiter #(.NUM_EXT(NUM_EXT)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_n     (req_n),
    .brg_req   (brg_req),
    .bus_idle  (bus_idle),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .gnt_n     (gnt_n),
    .brg_gnt   (brg_gnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // Scoreboard of expected grant onsets
  int    exp_id[$];
  string exp_tag[$];

  // Master models: remaining transactions, and hand-driven masters
  int cnt[NAG];
  bit manual[NAG];

  int  prev_id, cur_id, n_on;
  bit  prev_any, cur_any;
  logic [NAG-1:0] gv;

  task automatic push(int id, string tag);
    exp_id.push_back(id);
    exp_tag.push_back(tag);
  endtask

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit agent_req(int i);
    return (i == BRG) ? brg_req : !req_n[i];
  endfunction

  task automatic set_req(int i, bit on);
    if (i == BRG) brg_req = on;
    else          req_n[i] = !on;
  endtask

  // Monitor and master models, away from the active edge
  always @(negedge clk) begin
    gv = {brg_gnt, ~gnt_n};
    if (!rst_n) begin
      prev_any = 1'b0;
      prev_id  = -1;
    end else begin
      n_on    = $countones(gv);
      cur_any = (n_on != 0);
      cur_id  = -1;
      for (int i = 0; i < NAG; i++) if (gv[i]) cur_id = i;
      if (n_on > 1) begin
        tests++; fails++;
        $display("FAIL R3 several grants: actual 0x%0h expected one-hot", gv);
      end
      if (prev_any && cur_any && cur_id != prev_id) begin
        tests++; fails++;
        $display("FAIL R4 no gap: actual %0d expected gap after %0d", cur_id, prev_id);
      end
      if (cur_any && !prev_any) begin
        if (exp_id.size() == 0) begin
          tests++; fails++;
          $display("FAIL R6 unexpected grant: actual %0d expected none", cur_id);
        end else begin
          automatic int    e = exp_id.pop_front();
          automatic string t = exp_tag.pop_front();
          check(cur_id == e, t, "grant order", cur_id, e);
        end
      end
      for (int i = 0; i < NAG; i++) begin
        if (!manual[i]) begin
          if (gv[i] && agent_req(i)) begin
            set_req(i, 1'b0);
            cnt[i]--;
          end else if (!gv[i] && !agent_req(i) && cnt[i] > 0) begin
            set_req(i, 1'b1);
          end
        end
      end
      prev_any = cur_any;
      prev_id  = cur_id;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cfg_write(logic [31:0] v);
    step();
    cfg_wr = 1'b1;
    cfg_wdata = v;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic drain();
    int w = 0;
    while (exp_id.size() > 0 && w < 300) begin
      @(posedge clk);
      w++;
    end
    if (exp_id.size() > 0) begin
      tests++; fails++;
      $display("FAIL %s missing grant: actual none expected %0d", exp_tag[0], exp_id[0]);
      exp_id.delete();
      exp_tag.delete();
    end
    repeat (6) @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    req_n = '1;
    brg_req = 1'b0;
    bus_idle = 1'b1;
    cfg_wr = 1'b0;
    cfg_wdata = '0;
    for (int i = 0; i < NAG; i++) begin cnt[i] = 0; manual[i] = 1'b0; end

    repeat (3) @(negedge clk);
    check(gnt_n == '1, "R1", "gnt_n in reset", gnt_n, 8'hFF);
    check(brg_gnt == 1'b0, "R1", "brg_gnt in reset", brg_gnt, 0);
    check(cfg_rdata == 32'h0200_0000, "R1", "cfg reset value", cfg_rdata, 32'h0200_0000);

    // R8: first grant parks on the bridge
    push(BRG, "R8");
    rst_n = 1'b1;
    drain();

    // R6: low tier in index order, then rotation past the last served
    push(0, "R6"); push(1, "R6"); push(2, "R6");
    cnt[0] = 1; cnt[1] = 1; cnt[2] = 1;
    drain();
    push(3, "R6"); push(0, "R6"); push(1, "R6");
    cnt[0] = 1; cnt[1] = 1; cnt[3] = 1;
    drain();

    // R7: agents 2,3 and bridge high; 5,6 low
    cfg_write(32'h020C_0000);
    push(2, "R7"); push(3, "R7"); push(BRG, "R7"); push(5, "R7"); push(6, "R7");
    cnt[2] = 1; cnt[3] = 1; cnt[5] = 1; cnt[6] = 1; cnt[BRG] = 1;
    drain();

    // R7: one low agent per high pass
    push(2, "R7"); push(3, "R7"); push(4, "R7");
    push(2, "R7"); push(3, "R7"); push(5, "R7");
    cnt[2] = 2; cnt[3] = 2; cnt[4] = 1; cnt[5] = 1;
    drain();

    // R9: park on bridge
    push(BRG, "R9");
    cfg_write(32'h060C_0000);
    drain();
    push(4, "R6"); push(BRG, "R9");
    cnt[4] = 1;
    drain();

    // R10 / R5: owner holds its request; tier change and rival request
    manual[6] = 1'b1;
    push(6, "R10");
    set_req(6, 1'b1);
    drain();
    cfg_write(32'h028C_0000);
    manual[7] = 1'b1;
    set_req(7, 1'b1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(gnt_n[6] == 1'b0, "R10", "held grant after write", gnt_n, 8'hBF);
    step();
    bus_idle = 1'b0;
    set_req(6, 1'b0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(gnt_n[6] == 1'b0, "R5", "grant while bus busy", gnt_n, 8'hBF);
    step();
    push(7, "R5");
    bus_idle = 1'b1;
    drain();
    set_req(7, 1'b0);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(gnt_n[7] == 1'b0, "R8", "parked on last owner", gnt_n, 8'h7F);
    manual[6] = 1'b0;
    manual[7] = 1'b0;

    // R2: reserved bits and readback
    push(BRG, "R9");
    cfg_write(32'hFFFF_FFFF);
    @(negedge clk);
    check(cfg_rdata == 32'h06FF_0000, "R2", "all-ones write", cfg_rdata, 32'h06FF_0000);
    drain();
    cfg_write(32'h0000_0000);
    @(negedge clk);
    check(cfg_rdata == 32'h0000_0000, "R2", "zero write", cfg_rdata, 0);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(brg_gnt == 1'b1, "R8", "bridge stays parked", brg_gnt, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule